// File: doc/BRIEF.md
# Periodic Schedule Span-Node Walker

This block decides, one descriptor at a time, where a USB host controller goes next while it walks the periodic schedule for a micro-frame. At the start of each micro-frame it is given the first link of the list and the micro-frame number. It then asks for descriptors through a simple request/valid exchange. For each descriptor it receives, it produces the next address to fetch and says whether that descriptor's bus transaction may run. It stops when it reaches a terminated link.

Frame-span nodes steer the walk. In the first two micro-frames of a frame, a save-type span node diverts the walk onto its back path, which points into the previous frame's queue heads, and remembers the node's forward link. A later restore-type span node then resumes the walk from that remembered link. While the walk is on the diverted path, only queue-head transactions are enabled. The other nodes are passed over without being executed.

Top module: `per_span_walker`

## Requirements
- R1: After reset, `fetch_req`, `recov_mode` and `list_end` are all 0.
- R2: Every link uses bit 0 as the terminate flag, bits 2:1 as the node kind (0 isochronous, 1 queue head, 2 split isochronous, 3 span node) and bits 31:5 as the address. A pulse on `uframe_start` with an unterminated `start_link` raises `fetch_req` on the next cycle, with `fetch_addr` = {link[31:5], 5'b0}.
- R3: A span node whose back link has terminate 0 is a save node. When a save node is consumed in micro-frame 0 or 1 while `recov_mode` is 0, the next fetch goes to the back link's address, `recov_mode` becomes 1, and the node's forward link is stored.
- R4: In micro-frames 2 to 7, a save node is passed by following its forward link, and `recov_mode` is unchanged.
- R5: A span node whose back link has terminate 1 is a restore node. When a restore node is consumed while `recov_mode` is 1, `recov_mode` clears and the walk continues from the stored forward link. This rule takes precedence over every other reading of that node.
- R6: A restore node consumed while `recov_mode` is 0 is passed by following its own forward link.
- R7: `xact_en` is high for a consumed descriptor only if the descriptor is not a span node and, while `recov_mode` is 1, only if it is a queue head.
- R8: When the selected next link has terminate 1, `fetch_req` drops and `list_end` pulses high for exactly one cycle.
- R9: `sched_err` pulses with the consumed save node when a diversion is taken through a back link whose kind field is not queue head. The diversion still happens.
- R10: `uframe_start` clears `recov_mode` and the stored link and restarts the walk, even in the middle of a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_start | input | 1 | Begins a new micro-frame walk |
| uframe_idx | input | 3 | Current micro-frame number, 0..7 |
| start_link | input | 32 | First link of the list for this micro-frame |
| fetch_req | output | 1 | A descriptor fetch is wanted |
| fetch_addr | output | 32 | Aligned address of the descriptor to fetch |
| desc_valid | input | 1 | Fetched descriptor is present this cycle |
| desc_type | input | 2 | Kind of the fetched descriptor |
| desc_next | input | 32 | Forward link of the fetched descriptor |
| desc_back | input | 32 | Back link of the fetched descriptor (span nodes) |
| xact_en | output | 1 | Transaction of the consumed descriptor may run |
| sched_err | output | 1 | Diversion through a back link that is not a queue head |
| recov_mode | output | 1 | Walk is on the diverted (back) path |
| list_end | output | 1 | One-cycle pulse when the walk terminates |

## Verification
A directed schedule is walked in micro-frame 0 and in micro-frame 3. Comparing the two visit orders separates the diverting save behaviour from the pass-through behaviour, and it tells a restore reached in recovery apart from one reached outside it. A walk that is cut off while in recovery and then restarted shows whether the mode is cleared at a micro-frame boundary. Randomly linked schedules, swept across all eight micro-frames, mix bad back-link kinds, terminated stored links and repeated diversions. In these schedules every visited address, enable, mode value and error pulse is compared against a software walk of the same arrays.

// File: rtl/psw_pkg.sv
package psw_pkg;

  typedef enum logic [1:0] {
    LK_ISO  = 2'd0,
    LK_QH   = 2'd1,
    LK_SITD = 2'd2,
    LK_SPAN = 2'd3
  } link_kind_e;

  localparam int LINK_W    = 32;
  localparam int ALIGN_LSB = 5;

  function automatic logic link_term(input logic [LINK_W-1:0] p);
    return p[0];
  endfunction

  function automatic link_kind_e link_kind(input logic [LINK_W-1:0] p);
    return link_kind_e'(p[2:1]);
  endfunction

  function automatic logic [LINK_W-1:0] link_addr(input logic [LINK_W-1:0] p);
    return {p[LINK_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  endfunction

  // transaction permission: spans never run, recovery keeps queue heads only
  function automatic logic xact_allowed(input link_kind_e k, input logic recov);
    return (k != LK_SPAN) && (!recov || (k == LK_QH));
  endfunction

endpackage

// File: rtl/psw_node_classify.sv
module psw_node_classify
  import psw_pkg::*;
#(
  parameter int UF_W     = 3,
  parameter int EARLY_UF = 2
) (
  input  logic [1:0]        node_kind,
  input  logic [LINK_W-1:0] node_back,
  input  logic [UF_W-1:0]   uframe,
  input  logic              recov,
  output logic              is_save,
  output logic              is_restore,
  output logic              save_take,
  output logic              restore_take,
  output logic              back_bad,
  output logic              xact_ok
);
  link_kind_e kind;
  logic       early;

  always_comb begin
    kind         = link_kind_e'(node_kind);
    early        = (int'(uframe) < EARLY_UF);
    is_save      = (kind == LK_SPAN) && !link_term(node_back);
    is_restore   = (kind == LK_SPAN) &&  link_term(node_back);
    restore_take = is_restore && recov;
    save_take    = is_save && !recov && early;
    back_bad     = link_kind(node_back) != LK_QH;
    xact_ok      = xact_allowed(kind, recov);
  end
endmodule

// File: rtl/psw_path_ctl.sv
module psw_path_ctl
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              save_take,
  input  logic              restore_take,
  input  logic [LINK_W-1:0] fwd_link,
  output logic              recov,
  output logic [LINK_W-1:0] saved_link
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      recov      <= 1'b0;
      saved_link <= '0;
    end else if (clear) begin
      recov      <= 1'b0;
      saved_link <= '0;
    end else if (restore_take) begin
      recov      <= 1'b0;
    end else if (save_take) begin
      recov      <= 1'b1;
      saved_link <= fwd_link;
    end
  end
endmodule

// File: rtl/psw_fetch_seq.sv
module psw_fetch_seq
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [LINK_W-1:0] restart_link,
  input  logic              advance,
  input  logic [LINK_W-1:0] advance_link,
  output logic              busy,
  output logic [LINK_W-1:0] addr,
  output logic              done
);
  logic              load;
  logic [LINK_W-1:0] sel;

  always_comb begin
    load = restart || advance;
    sel  = restart ? restart_link : advance_link;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        if (link_term(sel)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          addr <= link_addr(sel);
        end
      end
    end
  end
endmodule

// File: rtl/per_span_walker.sv
module per_span_walker
  import psw_pkg::*;
#(
  parameter int UFRAMES  = 8,
  parameter int EARLY_UF = 2,
  localparam int UF_W    = $clog2(UFRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uframe_start,
  input  logic [UF_W-1:0]   uframe_idx,
  input  logic [LINK_W-1:0] start_link,
  output logic              fetch_req,
  output logic [LINK_W-1:0] fetch_addr,
  input  logic              desc_valid,
  input  logic [1:0]        desc_type,
  input  logic [LINK_W-1:0] desc_next,
  input  logic [LINK_W-1:0] desc_back,
  output logic              xact_en,
  output logic              sched_err,
  output logic              recov_mode,
  output logic              list_end
);
  // named internal events, visible to the bound checker
  logic              step;
  logic              is_save;
  logic              is_restore;
  logic              save_take;
  logic              restore_take;
  logic              back_bad;
  logic              xact_ok;
  logic [LINK_W-1:0] saved_link;
  logic [LINK_W-1:0] next_link;

  psw_node_classify #(.UF_W(UF_W), .EARLY_UF(EARLY_UF)) u_cls (
    .node_kind    (desc_type),
    .node_back    (desc_back),
    .uframe       (uframe_idx),
    .recov        (recov_mode),
    .is_save      (is_save),
    .is_restore   (is_restore),
    .save_take    (save_take),
    .restore_take (restore_take),
    .back_bad     (back_bad),
    .xact_ok      (xact_ok)
  );

  psw_path_ctl u_path (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (uframe_start),
    .save_take    (step && save_take),
    .restore_take (step && restore_take),
    .fwd_link     (desc_next),
    .recov        (recov_mode),
    .saved_link   (saved_link)
  );

  always_comb begin
    step = fetch_req && desc_valid && !uframe_start;
    if (restore_take)   next_link = saved_link;
    else if (save_take) next_link = desc_back;
    else                next_link = desc_next;
    xact_en   = step && xact_ok;
    sched_err = step && save_take && back_bad;
  end

  psw_fetch_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (uframe_start),
    .restart_link (start_link),
    .advance      (step),
    .advance_link (next_link),
    .busy         (fetch_req),
    .addr         (fetch_addr),
    .done         (list_end)
  );
endmodule

// File: rtl/psw_checker.sv
module psw_checker
  import psw_pkg::*;
#(
  parameter int UF_W     = 3,
  parameter int EARLY_UF = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uframe_start,
  input logic [UF_W-1:0]   uframe_idx,
  input logic [1:0]        desc_type,
  input logic [LINK_W-1:0] desc_back,
  input logic              step,
  input logic              is_save,
  input logic              save_take,
  input logic              restore_take,
  input logic [LINK_W-1:0] saved_link,
  input logic              recov_mode,
  input logic              fetch_req,
  input logic [LINK_W-1:0] fetch_addr,
  input logic              list_end,
  input logic              xact_en
);
  a_r3_divert_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    step && save_take |=> recov_mode && fetch_req && fetch_addr == link_addr($past(desc_back)));

  a_r4_late_save_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    step && is_save && (int'(uframe_idx) >= EARLY_UF) |=> recov_mode == $past(recov_mode));

  a_r5_restore_resumes: assert property (@(posedge clk) disable iff (!rst_n)
    step && restore_take && !saved_link[0] |=> !recov_mode && fetch_addr == link_addr($past(saved_link)));

  a_r7_span_never_runs: assert property (@(posedge clk) disable iff (!rst_n)
    step && desc_type == LK_SPAN |-> !xact_en);

  a_r7_recovery_qh_only: assert property (@(posedge clk) disable iff (!rst_n)
    step && recov_mode && desc_type != LK_QH |-> !xact_en);

  a_r8_end_stops_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    list_end |-> !fetch_req);

  a_r10_start_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_start |=> !recov_mode);
endmodule

bind per_span_walker psw_checker #(.UF_W(UF_W), .EARLY_UF(EARLY_UF)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .uframe_start (uframe_start),
  .uframe_idx   (uframe_idx),
  .desc_type    (desc_type),
  .desc_back    (desc_back),
  .step         (step),
  .is_save      (is_save),
  .save_take    (save_take),
  .restore_take (restore_take),
  .saved_link   (saved_link),
  .recov_mode   (recov_mode),
  .fetch_req    (fetch_req),
  .fetch_addr   (fetch_addr),
  .list_end     (list_end),
  .xact_en      (xact_en)
);

// File: tb/per_span_walker_bench.sv
module per_span_walker_bench;
  localparam int NN   = 16;
  localparam int MAXS = 40;
  localparam logic [31:0] BASE = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uframe_start = 1'b0;
  logic [2:0]  uframe_idx = '0;
  logic [31:0] start_link = '0;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        desc_valid = 1'b0;
  logic [1:0]  desc_type = '0;
  logic [31:0] desc_next = '0;
  logic [31:0] desc_back = '0;
  logic        xact_en, sched_err, recov_mode, list_end;

  always #5 clk = ~clk;

  per_span_walker u_per_span_walker (
    .clk(clk), .rst_n(rst_n), .uframe_start(uframe_start), .uframe_idx(uframe_idx),
    .start_link(start_link), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .desc_valid(desc_valid), .desc_type(desc_type), .desc_next(desc_next),
    .desc_back(desc_back), .xact_en(xact_en), .sched_err(sched_err),
    .recov_mode(recov_mode), .list_end(list_end)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [1:0]  m_kind [NN];
  logic [31:0] m_fwd  [NN];
  logic [31:0] m_bk   [NN];

  int          e_idx [MAXS];
  logic        e_en  [MAXS];
  logic        e_rec [MAXS];
  logic        e_err [MAXS];
  int          e_n;
  logic        e_end;

  function automatic logic [31:0] lnk(int idx, int kind, int term);
    return BASE + 32'(idx) * 32 + 32'(kind * 2) + 32'(term);
  endfunction

  function automatic int node_of(logic [31:0] p);
    return int'(((p & 32'hFFFF_FFE0) - BASE) >> 5);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // software walk of the arrays, stated from the requirements
  task automatic model_walk(logic [31:0] first, int uf);
    logic [31:0] p = first;
    logic [31:0] keep = '0;
    logic        rec = 1'b0;
    e_n = 0;
    e_end = 1'b0;
    while (e_n < MAXS) begin
      int i;
      logic span, saver, restorer;
      if (p[0]) begin e_end = 1'b1; break; end
      i = node_of(p);
      span = (m_kind[i] == 2'd3);
      restorer = span && m_bk[i][0];
      saver = span && !m_bk[i][0];
      e_idx[e_n] = i;
      e_rec[e_n] = rec;
      e_en[e_n]  = !span && (rec ? (m_kind[i] == 2'd1) : 1'b1);
      e_err[e_n] = 1'b0;
      if (rec && restorer) begin
        p = keep; rec = 1'b0;
      end else if (!rec && saver && uf <= 1) begin
        keep = m_fwd[i]; p = m_bk[i]; rec = 1'b1;
        e_err[e_n] = (m_bk[i][2:1] != 2'd1);
      end else begin
        p = m_fwd[i];
      end
      e_n++;
    end
  endtask

  // run one micro-frame on the DUT; cut < MAXS abandons the walk early
  task automatic run_frame(logic [31:0] first, int uf, int cut, string tag);
    int steps = 0;
    logic saw_end = 1'b0;
    model_walk(first, uf);
    @(negedge clk);
    desc_valid = 1'b0;
    uframe_start = 1'b1;
    uframe_idx = 3'(uf);
    start_link = first;
    @(posedge clk);
    @(negedge clk);
    uframe_start = 1'b0;
    chk("R10", {tag, " mode after start"}, 32'(recov_mode), 32'd0);
    while (steps < cut && steps < MAXS) begin
      int i;
      if (!fetch_req) begin saw_end = list_end; break; end
      chk("R2", {tag, " fetch address"}, fetch_addr,
          (steps < e_n) ? BASE + 32'(e_idx[steps]) * 32 : 32'hDEAD_BEEF);
      i = node_of(fetch_addr);
      if (i < 0 || i >= NN) i = 0;
      desc_type = m_kind[i];
      desc_next = m_fwd[i];
      desc_back = m_bk[i];
      desc_valid = 1'b1;
      #1;
      if (steps < e_n) begin
        chk("R7", {tag, " xact_en"}, 32'(xact_en), 32'(e_en[steps]));
        chk("R3", {tag, " recov_mode"}, 32'(recov_mode), 32'(e_rec[steps]));
        chk("R9", {tag, " sched_err"}, 32'(sched_err), 32'(e_err[steps]));
      end
      steps++;
      @(posedge clk);
      @(negedge clk);
    end
    desc_valid = 1'b0;
    if (cut >= MAXS) begin
      if (steps < MAXS && fetch_req == 1'b0) saw_end = list_end;
      chk("R5", {tag, " step count"}, 32'(steps), 32'(e_n));
      chk("R8", {tag, " end pulse"}, 32'(saw_end), 32'(e_end));
      if (e_end) begin
        @(negedge clk);
        chk("R8", {tag, " end pulse width"}, 32'(list_end), 32'd0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "fetch_req in reset", 32'(fetch_req), 32'd0);
    chk("R1", "recov_mode in reset", 32'(recov_mode), 32'd0);
    chk("R1", "list_end in reset", 32'(list_end), 32'd0);
    rst_n = 1'b1;

    // directed schedule: 0 QH,1 ISO,2 SAVE(back 4, fwd 5),4 QH,6 ISO,7 RESTORE(fwd 8),5 QH,8 QH end
    for (int k = 0; k < NN; k++) begin
      m_kind[k] = 2'd0; m_fwd[k] = 32'h1; m_bk[k] = 32'h1;
    end
    m_kind[0] = 2'd1; m_fwd[0] = lnk(1, 0, 0);
    m_kind[1] = 2'd0; m_fwd[1] = lnk(2, 3, 0);
    m_kind[2] = 2'd3; m_fwd[2] = lnk(5, 1, 0); m_bk[2] = lnk(4, 1, 0);
    m_kind[4] = 2'd1; m_fwd[4] = lnk(6, 0, 0);
    m_kind[6] = 2'd0; m_fwd[6] = lnk(7, 3, 0);
    m_kind[7] = 2'd3; m_fwd[7] = lnk(8, 1, 0); m_bk[7] = 32'h1;
    m_kind[5] = 2'd1; m_fwd[5] = lnk(7, 3, 0);
    m_kind[8] = 2'd1; m_fwd[8] = 32'h1;

    // R3, R5, R6: early micro-frame diverts then restores
    model_walk(lnk(0, 1, 0), 0);
    chk("R5", "directed uf0 order length", 32'(e_n), 32'd9);
    run_frame(lnk(0, 1, 0), 0, MAXS, "uf0");
    // R4: late micro-frame passes the save node
    model_walk(lnk(0, 1, 0), 3);
    chk("R4", "directed uf3 order length", 32'(e_n), 32'd6);
    run_frame(lnk(0, 1, 0), 3, MAXS, "uf3");
    // R10: abandon in recovery, restart
    run_frame(lnk(0, 1, 0), 1, 4, "cut");
    chk("R10", "mode held before restart", 32'(recov_mode), 32'd1);
    run_frame(lnk(0, 1, 0), 1, MAXS, "restart");
    // R8, R2: terminated start link
    run_frame(32'h1, 0, MAXS, "empty");
    // R9: back link of wrong kind
    m_bk[2] = lnk(4, 0, 0);
    run_frame(lnk(0, 1, 0), 0, MAXS, "badback");

    // random schedules across every micro-frame
    for (int s = 0; s < 6; s++) begin
      for (int k = 0; k < NN; k++) m_kind[k] = 2'($urandom_range(0, 3));
      for (int k = 0; k < NN; k++) begin
        if (k == NN - 1 || $urandom_range(0, 3) == 0) m_fwd[k] = lnk(0, 0, 1);
        else begin
          int j = $urandom_range(k + 1, NN - 1);
          m_fwd[k] = lnk(j, int'(m_kind[j]), 0);
        end
        if ($urandom_range(0, 1) == 1) m_bk[k] = 32'h1;
        else begin
          int j = $urandom_range(0, NN - 1);
          m_bk[k] = lnk(j, ($urandom_range(0, 4) == 0) ? $urandom_range(0, 3) : 1, 0);
        end
      end
      for (int uf = 0; uf < 8; uf++)
        run_frame(lnk($urandom_range(0, 3), 1, ($urandom_range(0, 9) == 0) ? 1 : 0),
                  uf, MAXS, "rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule